// File: doc/BRIEF.md
# Data Float Turnaround Arbiter

This block protects a shared external data bus after a read from a slow device. When a read finishes, the device can keep driving the data lines for a programmed number of clock cycles. The block marks the bus busy for that float time plus one fixed turnaround cycle. While the bus is busy, it holds off a pending access from any other chip select, so that two devices never drive the lines at once.

Each chip select has four settings: a float count from 0 to 15, an optimization enable, and two mode bits. The mode bits say whether reads and writes are timed by the chip-select line or by the read or write strobe. The read mode bit also picks which rising edge starts the busy window. If the releasing chip select has optimization disabled, the next access from another chip select waits out every remaining busy cycle. If optimization is enabled, the remaining busy cycles overlap the setup phase of the next access, and only the part that the setup does not cover is charged as stall.

The surrounding controller reports two pulses: the rising edge of the chip-select line and the rising edge of the read strobe, both tagged with the chip select of the read. It presents the next requested access together with its three setup lengths. The block answers in the same cycle with grant, stall and the number of wait cycles.

Top module: `tdf_turnaround_arb`

## Requirements
- R1: After reset the bus is not busy, and any valid request is granted with zero wait.
- R2: A trigger loads a busy window of float count plus one cycles, starting on the next clock edge. A float count of 0 gives exactly one busy cycle. The window drops by one each cycle until it reaches zero.
- R3: The trigger edge follows the read mode bit of the reporting chip select. Mode 0 triggers on the chip-select rising pulse and mode 1 on the read-strobe rising pulse. The other pulse is ignored and leaves the bus not busy.
- R4: A request from the chip select that owns the current window is granted with zero wait.
- R5: When the owner's optimization bit, captured at the trigger, is 0, a request from another chip select stalls with a wait equal to the remaining busy cycles.
- R6: When the captured optimization bit is 1, the wait is the remaining busy cycles minus the setup length of the next access, floored at zero. A read uses the chip-select setup if its read mode is 0 and the read-strobe setup if it is 1. A write uses the chip-select setup if its write mode is 0 and the write-strobe setup if it is 1.
- R7: A trigger while a window is still counting reloads the count from the new chip select's float value and makes that chip select the new owner.
- R8: Grant is high when the request is valid and the wait is zero. Stall is high when the request is valid and the wait is nonzero. With no valid request, grant, stall and wait are all zero.
- R9: The float count of chip select i sits in bits [4i+3:4i] of the packed float count input. The configuration bits of chip select i sit at bit i of the enable and mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_float_cnt | input | 16 | Packed 4-bit float counts, one per chip select |
| cfg_opt_en | input | 4 | Optimization enable per chip select |
| cfg_rd_mode | input | 4 | Read mode per chip select (0 chip-select timed, 1 strobe timed) |
| cfg_wr_mode | input | 4 | Write mode per chip select (0 chip-select timed, 1 strobe timed) |
| evt_cs | input | 2 | Chip select of the read reporting an edge |
| evt_sel_rise | input | 1 | Chip-select line rising pulse |
| evt_rd_rise | input | 1 | Read strobe rising pulse |
| req_valid | input | 1 | Next access is pending |
| req_cs | input | 2 | Chip select of the next access |
| req_write | input | 1 | Next access is a write |
| req_sel_setup | input | 6 | Chip-select setup length of the next access |
| req_rd_setup | input | 6 | Read-strobe setup length of the next access |
| req_wr_setup | input | 6 | Write-strobe setup length of the next access |
| bus_busy | output | 1 | Float window is active |
| req_grant | output | 1 | Next access may start |
| req_stall | output | 1 | Next access must wait |
| req_wait | output | 5 | Wait cycles charged to the next access |

## Verification
The bench checks the zero float count, which must still give one busy cycle. A design that dropped the turnaround cycle would leave the bus free at once. It sends the pulse that the read mode says to ignore; a design that reacted to both edges would raise busy. It sends a request from the owning chip select inside a live window, which a design that blocked every chip select would stall. It also starts a fresh read over a long window: a design that kept counting the old window would report too many busy cycles. Optimized requests use each of the three setup sources and a setup that covers the whole window. A wrong source pick or a missing floor would then give a wrong wait or a wrapped-around value.

// File: rtl/tdf_arb_pkg.sv
// Package: shared helpers for the data float turnaround arbiter.
// Assumes: callers pass operands already widened to a common width.
package tdf_arb_pkg;

    // Source of the setup length that hides float cycles.
    typedef enum logic [1:0] {
        SETUP_FROM_SEL = 2'd0,
        SETUP_FROM_RD  = 2'd1,
        SETUP_FROM_WR  = 2'd2
    } setup_src_e;

    // Saturating subtraction used for the optimized wait count.
    function automatic logic [15:0] sat_sub16(input logic [15:0] a, input logic [15:0] b);
        return (a > b) ? (a - b) : 16'd0;
    endfunction

endpackage

// File: rtl/tdf_trigger_sel.sv
// Module: turns edge pulses into a window load request.
// Each chip select keeps its own read mode bit, which picks the edge that
// counts. This module also fetches that chip select's float count (plus the
// turnaround cycle) and its optimization bit.
// Assumes: at most one read reports per cycle; NUM_CS >= 2.
module tdf_trigger_sel #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int REM_W = CNT_W + 1
) (
    input  logic [NUM_CS*CNT_W-1:0] cfg_float_cnt,
    input  logic [NUM_CS-1:0]       cfg_opt_en,
    input  logic [NUM_CS-1:0]       cfg_rd_mode,
    input  logic [CS_W-1:0]         evt_cs,
    input  logic                    evt_sel_rise,
    input  logic                    evt_rd_rise,
    output logic                    start,
    output logic [REM_W-1:0]        load_val,
    output logic                    load_opt
);

    logic [NUM_CS-1:0] hit;
    logic [CNT_W-1:0]  cnt_of [NUM_CS];

    // One qualified-edge detector per chip select.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign cnt_of[gi] = cfg_float_cnt[gi*CNT_W +: CNT_W];
        assign hit[gi]    = (evt_cs == CS_W'(gi)) &&
                            (cfg_rd_mode[gi] ? evt_rd_rise : evt_sel_rise);
    end

    // Merge the per-chip-select hits into one load request.
    always_comb begin
        start    = |hit;
        load_val = '0;
        load_opt = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit[i]) begin
                load_val = REM_W'(cnt_of[i]) + REM_W'(1);
                load_opt = cfg_opt_en[i];
            end
        end
    end

endmodule

// File: rtl/tdf_window_cnt.sv
// Module: busy window down-counter with owner tracking.
// A load overrides any count in progress. Otherwise the count drops by one
// per cycle down to zero. The owner and its optimization bit are held until
// the next load.
// Assumes: load_val is nonzero whenever start is high.
module tdf_window_cnt #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int REM_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REM_W-1:0] load_val,
    input  logic [CS_W-1:0]  load_cs,
    input  logic             load_opt,
    output logic [REM_W-1:0] rem,
    output logic [CS_W-1:0]  owner,
    output logic             owner_opt
);

    // Reload on a trigger, else count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (start) begin
            rem <= load_val;
        end else if (rem != '0) begin
            rem <= rem - REM_W'(1);
        end
    end

    // Capture which chip select owns the window and how it releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner     <= '0;
            owner_opt <= 1'b0;
        end else if (start) begin
            owner     <= load_cs;
            owner_opt <= load_opt;
        end
    end

endmodule

// File: rtl/tdf_setup_pick.sv
// Module: picks the setup length of the next access that may hide float
// cycles. Reads and writes each use their own mode bit for the requesting
// chip select.
// Assumes: setup lengths are already valid for req_cs.
module tdf_setup_pick
    import tdf_arb_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int SETUP_W = 6,
    localparam int CS_W   = $clog2(NUM_CS)
) (
    input  logic [CS_W-1:0]    req_cs,
    input  logic               req_write,
    input  logic [NUM_CS-1:0]  cfg_rd_mode,
    input  logic [NUM_CS-1:0]  cfg_wr_mode,
    input  logic [SETUP_W-1:0] req_sel_setup,
    input  logic [SETUP_W-1:0] req_rd_setup,
    input  logic [SETUP_W-1:0] req_wr_setup,
    output logic [SETUP_W-1:0] setup_len
);

    setup_src_e src;

    // Decide which strobe's setup applies.
    always_comb begin
        if (req_write) begin
            src = cfg_wr_mode[req_cs] ? SETUP_FROM_WR : SETUP_FROM_SEL;
        end else begin
            src = cfg_rd_mode[req_cs] ? SETUP_FROM_RD : SETUP_FROM_SEL;
        end
    end

    // Route the chosen setup length.
    always_comb begin
        case (src)
            SETUP_FROM_RD: setup_len = req_rd_setup;
            SETUP_FROM_WR: setup_len = req_wr_setup;
            default:       setup_len = req_sel_setup;
        endcase
    end

endmodule

// File: rtl/tdf_turnaround_arb.sv
// Top: data float turnaround arbiter.
// Tracks the float-plus-turnaround window after each read and charges wait
// cycles to a next access from a different chip select. The charge is either
// the full remainder or the part its setup phase does not cover.
// Assumes: one event and one request per cycle; outputs are combinational
// from the registered window and the current request.
module tdf_turnaround_arb
    import tdf_arb_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int CNT_W   = 4,
    parameter int SETUP_W = 6,
    localparam int CS_W   = $clog2(NUM_CS),
    localparam int REM_W  = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*CNT_W-1:0] cfg_float_cnt,
    input  logic [NUM_CS-1:0]       cfg_opt_en,
    input  logic [NUM_CS-1:0]       cfg_rd_mode,
    input  logic [NUM_CS-1:0]       cfg_wr_mode,
    input  logic [CS_W-1:0]         evt_cs,
    input  logic                    evt_sel_rise,
    input  logic                    evt_rd_rise,
    input  logic                    req_valid,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_write,
    input  logic [SETUP_W-1:0]      req_sel_setup,
    input  logic [SETUP_W-1:0]      req_rd_setup,
    input  logic [SETUP_W-1:0]      req_wr_setup,
    output logic                    bus_busy,
    output logic                    req_grant,
    output logic                    req_stall,
    output logic [REM_W-1:0]        req_wait
);

    logic               start;
    logic [REM_W-1:0]   load_val;
    logic               load_opt;
    logic [REM_W-1:0]   win_rem;
    logic [CS_W-1:0]    win_owner;
    logic               win_opt;
    logic [SETUP_W-1:0] setup_len;
    logic [15:0]        hidden_wait;

    tdf_trigger_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_trig (
        .cfg_float_cnt (cfg_float_cnt),
        .cfg_opt_en    (cfg_opt_en),
        .cfg_rd_mode   (cfg_rd_mode),
        .evt_cs        (evt_cs),
        .evt_sel_rise  (evt_sel_rise),
        .evt_rd_rise   (evt_rd_rise),
        .start         (start),
        .load_val      (load_val),
        .load_opt      (load_opt)
    );

    tdf_window_cnt #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_val  (load_val),
        .load_cs   (evt_cs),
        .load_opt  (load_opt),
        .rem       (win_rem),
        .owner     (win_owner),
        .owner_opt (win_opt)
    );

    tdf_setup_pick #(.NUM_CS(NUM_CS), .SETUP_W(SETUP_W)) u_pick (
        .req_cs        (req_cs),
        .req_write     (req_write),
        .cfg_rd_mode   (cfg_rd_mode),
        .cfg_wr_mode   (cfg_wr_mode),
        .req_sel_setup (req_sel_setup),
        .req_rd_setup  (req_rd_setup),
        .req_wr_setup  (req_wr_setup),
        .setup_len     (setup_len)
    );

    // Remaining busy cycles not hidden by the next access's setup.
    always_comb begin
        hidden_wait = sat_sub16(16'(win_rem), 16'(setup_len));
    end

    // Charge the wait and derive grant or stall for the pending access.
    always_comb begin
        bus_busy = (win_rem != '0);
        if (!req_valid || !bus_busy || (req_cs == win_owner)) begin
            req_wait = '0;
        end else if (win_opt) begin
            req_wait = REM_W'(hidden_wait);
        end else begin
            req_wait = win_rem;
        end
        req_grant = req_valid && (req_wait == '0);
        req_stall = req_valid && (req_wait != '0);
    end

endmodule

// File: rtl/tdf_arb_checker.sv
// Checker: temporal properties of the turnaround arbiter, bound to the top.
module tdf_arb_checker #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int REM_W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [REM_W-1:0] load_val,
    input logic [REM_W-1:0] win_rem,
    input logic [CS_W-1:0]  win_owner,
    input logic             win_opt,
    input logic             bus_busy,
    input logic             req_valid,
    input logic [CS_W-1:0]  req_cs,
    input logic             req_grant,
    input logic             req_stall,
    input logic [REM_W-1:0] req_wait
);

    assert_free_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_busy) |-> req_grant);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rem != '0 && !start) |=> (win_rem == $past(win_rem) - REM_W'(1)));

    assert_stay_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rem == '0 && !start) |=> (win_rem == '0));

    assert_owner_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bus_busy && req_cs == win_owner) |-> req_grant);

    assert_full_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bus_busy && !win_opt && req_cs != win_owner)
        |-> (req_stall && req_wait == win_rem));

    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_wait <= win_rem);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (win_rem == $past(load_val)));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !req_stall && req_wait == '0));

endmodule

bind tdf_turnaround_arb tdf_arb_checker #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_val  (load_val),
    .win_rem   (win_rem),
    .win_owner (win_owner),
    .win_opt   (win_opt),
    .bus_busy  (bus_busy),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .req_grant (req_grant),
    .req_stall (req_stall),
    .req_wait  (req_wait)
);

// File: tb/sim_tdf_turnaround_arb.sv
// Scoreboard bench: the driver pushes expectations, the monitor compares.
module sim_tdf_turnaround_arb;

    localparam int CLK_P = 10;

    typedef struct {
        string      tag;
        logic       busy;
        logic       grant;
        logic       stall;
        logic [4:0] wt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_float_cnt;
    logic [3:0]  cfg_opt_en, cfg_rd_mode, cfg_wr_mode;
    logic [1:0]  evt_cs = '0;
    logic        evt_sel_rise = 1'b0, evt_rd_rise = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cs = '0;
    logic        req_write = 1'b0;
    logic [5:0]  req_sel_setup = '0, req_rd_setup = '0, req_wr_setup = '0;
    logic        bus_busy, req_grant, req_stall;
    logic [4:0]  req_wait;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    int b_float[4] = '{3, 0, 5, 15};
    bit b_opt[4]   = '{1'b0, 1'b0, 1'b1, 1'b1};
    bit b_rdm[4]   = '{1'b0, 1'b1, 1'b1, 1'b0};
    bit b_wrm[4]   = '{1'b0, 1'b1, 1'b1, 1'b0};

    int m_rem = 0;
    int m_owner = 0;
    bit m_opt = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cfg_float_cnt[i*4 +: 4] = 4'(b_float[i]);
            cfg_opt_en[i]  = b_opt[i];
            cfg_rd_mode[i] = b_rdm[i];
            cfg_wr_mode[i] = b_wrm[i];
        end
    end

    tdf_turnaround_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_float_cnt(cfg_float_cnt), .cfg_opt_en(cfg_opt_en),
        .cfg_rd_mode(cfg_rd_mode), .cfg_wr_mode(cfg_wr_mode),
        .evt_cs(evt_cs), .evt_sel_rise(evt_sel_rise), .evt_rd_rise(evt_rd_rise),
        .req_valid(req_valid), .req_cs(req_cs), .req_write(req_write),
        .req_sel_setup(req_sel_setup), .req_rd_setup(req_rd_setup),
        .req_wr_setup(req_wr_setup),
        .bus_busy(bus_busy), .req_grant(req_grant), .req_stall(req_stall),
        .req_wait(req_wait)
    );

    // Driver: apply one cycle of stimulus, push the expectation, advance model.
    task automatic tick(input string tag, input int ecs, input bit srise, input bit rrise,
                        input bit rv, input int rcs, input bit rw,
                        input int ss, input int rs, input int ws);
        exp_t e;
        int setup, w;
        @(negedge clk);
        evt_cs = 2'(ecs); evt_sel_rise = srise; evt_rd_rise = rrise;
        req_valid = rv; req_cs = 2'(rcs); req_write = rw;
        req_sel_setup = 6'(ss); req_rd_setup = 6'(rs); req_wr_setup = 6'(ws);
        if (rw) setup = b_wrm[rcs] ? ws : ss;
        else    setup = b_rdm[rcs] ? rs : ss;
        if (!rv || m_rem == 0 || rcs == m_owner) w = 0;
        else if (m_opt) w = (m_rem > setup) ? m_rem - setup : 0;
        else w = m_rem;
        e.tag = tag; e.busy = (m_rem != 0); e.wt = 5'(w);
        e.grant = rv && (w == 0); e.stall = rv && (w != 0);
        sb_q.push_back(e);
        @(posedge clk);
        if (b_rdm[ecs] ? rrise : srise) begin
            m_rem = b_float[ecs] + 1; m_owner = ecs; m_opt = b_opt[ecs];
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
        end
    endtask

    // Monitor: sample a quarter period after the drive, compare to queue head.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (bus_busy !== e.busy || req_grant !== e.grant ||
                    req_stall !== e.stall || req_wait !== e.wt) begin
                    bad++;
                    $display("FAIL %s: busy/grant/stall/wait got %0b/%0b/%0b/%0d exp %0b/%0b/%0b/%0d",
                             e.tag, bus_busy, req_grant, req_stall, req_wait,
                             e.busy, e.grant, e.stall, e.wt);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P*200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang exp finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, free bus grants anyone
        tick("R1", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        tick("R1", 0, 0, 0, 1, 3, 1, 0, 0, 0);
        // R2 R5: cs0 float 3 via chip-select edge, cs1 waits full 4..1
        tick("R2", 0, 1, 0, 1, 1, 0, 9, 9, 9);
        for (int k = 0; k < 4; k++) tick("R5", 0, 0, 0, 1, 1, 0, 9, 9, 9);
        tick("R2", 0, 0, 0, 1, 1, 0, 9, 9, 9);
        // R3: wrong edge ignored for cs0 (mode 0) and cs1 (mode 1)
        tick("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
        tick("R3", 1, 1, 0, 1, 2, 0, 0, 0, 0);
        tick("R3", 1, 0, 0, 1, 2, 0, 0, 0, 0);
        // R2: cs1 zero float via read strobe gives one busy cycle
        tick("R2", 1, 0, 1, 1, 2, 0, 0, 0, 0);
        tick("R2", 0, 0, 0, 1, 2, 0, 0, 0, 0);
        tick("R2", 0, 0, 0, 1, 2, 0, 0, 0, 0);
        // R4: owner cs0 passes through its own window, others stall
        tick("R4", 0, 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R4", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        tick("R4", 0, 0, 0, 1, 0, 1, 0, 0, 0);
        tick("R5", 0, 0, 0, 1, 3, 1, 7, 7, 7);
        tick("R8", 0, 0, 0, 0, 3, 0, 0, 0, 0);
        tick("R8", 0, 0, 0, 0, 3, 0, 0, 0, 0);
        // R6: cs2 optimized window of 6, three setup sources
        tick("R6", 2, 0, 1, 0, 0, 0, 0, 0, 0);
        tick("R6", 0, 0, 0, 1, 0, 0, 2, 30, 30);
        tick("R6", 0, 0, 0, 1, 1, 0, 30, 1, 30);
        tick("R6", 0, 0, 0, 1, 1, 1, 30, 30, 1);
        tick("R6", 0, 0, 0, 1, 3, 1, 40, 0, 0);
        tick("R6", 0, 0, 0, 1, 0, 1, 1, 0, 0);
        tick("R6", 0, 0, 0, 1, 3, 0, 0, 0, 0);
        tick("R6", 0, 0, 0, 1, 3, 0, 0, 0, 0);
        // R7 R9: cs3 float 15 then reload by cs1 read while counting
        tick("R9", 3, 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R9", 0, 0, 0, 1, 0, 0, 3, 0, 0);
        tick("R9", 0, 0, 0, 1, 0, 0, 15, 0, 0);
        tick("R7", 1, 0, 1, 1, 3, 0, 0, 0, 0);
        tick("R7", 0, 0, 0, 1, 3, 0, 0, 0, 0);
        tick("R7", 0, 0, 0, 1, 3, 0, 0, 0, 0);
        // R7: reload to a longer window with a different owner
        tick("R7", 1, 0, 1, 0, 0, 0, 0, 0, 0);
        tick("R7", 0, 1, 0, 1, 1, 0, 0, 0, 0);
        tick("R7", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        tick("R7", 0, 0, 0, 1, 2, 0, 0, 0, 0);
        tick("R8", 0, 0, 0, 0, 2, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule